// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

This block is a synthesizable model of a synchronous static RAM whose data bus runs the same timing for reads and writes. A read or write is accepted on a rising clock edge. Its data occupies the bus in the cycle that starts two edges later. Because both directions share that slot, commands can alternate between read and write on every cycle with no idle cycle between them. Read data comes from an output register. Write data is taken from the bus at the edge that closes its slot, under per-lane write enables latched with the command.

Bursts of four words are supported through a 2-bit counter. Raising the advance input repeats the last read or write at the next burst address, and the address, write-enable and chip-select pins are ignored on that cycle. A sleep input freezes command acceptance but keeps the array and the burst position. The control is a four-state machine:

- `ST_IDLE`: no burst is open.
- `ST_RD_BURST`: a read burst is open.
- `ST_WR_BURST`: a write burst is open.
- `ST_SLEEP`: sleep is asserted. The state that was active on entry is saved in a resume register.

The transitions are:

- load-read: selected with `wr_n` high, into `ST_RD_BURST`.
- load-write: selected with `wr_n` low, into `ST_WR_BURST`.
- advance: stays in the open burst state.
- deselect: back to `ST_IDLE`.
- doze: any state to `ST_SLEEP` when sleep is high.
- wake: out of `ST_SLEEP` into the saved state, and that edge already accepts a command.

Top module: `zt_sync_sram`

## Requirements
- R1: While reset is low, and after it is released with no command issued, the block does not drive `data_io`.
- R2: A read accepted at edge n puts the stored word on `data_io` from just after edge n+2 until edge n+3, provided `out_en_n` is low.
- R3: For a write accepted at edge n, the word on `data_io` at edge n+3 is stored.
- R4: Reads and writes may be issued on consecutive edges in any mix, with no idle cycle, and each returns or stores its own word.
- R5: `lane_wr_n[i]` low, sampled with the write command, stores bits 8i+7..8i. A lane whose bit is high keeps its old contents.
- R6: A command is accepted only when `cs0_n`=0, `cs1`=1 and `cs2_n`=0 with `burst_adv`=0. Otherwise the cycle is a deselect: nothing is written and nothing is driven in its slot.
- R7: With `lin_order`=1, the low two address bits of burst step k (k=1,2,3) are (loaded bits + k) mod 4. The upper bits are unchanged.
- R8: With `lin_order`=0, the low two address bits of burst step k are the loaded bits XOR k. The upper bits are unchanged.
- R9: `burst_adv`=1 repeats the open burst's operation at the next burst address and ignores `addr`, `wr_n` and the chip selects. With no open burst it does nothing.
- R10: `out_en_n` acts without a clock. When it is high, `data_io` is released at once, even during a read slot.
- R11: While `sleep`=1, commands are ignored, and the array and the burst position are kept. After `sleep` falls, an advance continues the burst where it stopped.
- R12: A read accepted one edge after a write to the same address returns the new word, merged lane by lane with the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset of control and pipeline |
| addr | input | ADDR_W | Word address, loaded at the start of a burst |
| burst_adv | input | 1 | Continue the open burst at the next address |
| wr_n | input | 1 | 0 = write, 1 = read, on a load cycle |
| cs0_n | input | 1 | Chip select, active low |
| cs1 | input | 1 | Chip select, active high |
| cs2_n | input | 1 | Chip select, active low |
| lane_wr_n | input | LANES | Per-lane write enables, active low |
| lin_order | input | 1 | 1 = linear burst order, 0 = interleaved |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Sleep request, active high |
| data_io | inout | DATA_W | Shared three-state data bus |

## Verification
A wrong control state shows up two edges later as a drive on `data_io` in a slot that should float, or as a read returning the wrong word. For example, a burst that was not kept over sleep rereads the loaded address instead of the next one. A broken burst counter or order select shows up on the first advance, as a word from the wrong location in the slot two edges later. A broken write pipeline stays hidden until that location is read. For this reason every write in the stimulus is read back, some on the very next edge so that the bypass path is also covered.

// File: rtl/zt_pkg.sv
package zt_pkg;
    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } zt_op_e;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_RD_BURST = 2'd1,
        ST_WR_BURST = 2'd2,
        ST_SLEEP    = 2'd3
    } zt_state_e;
endpackage

// File: rtl/zt_ctrl.sv
module zt_ctrl
    import zt_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   sleep,
    input  logic   adv,
    input  logic   sel,
    input  logic   wr_n,
    output zt_op_e op_o,
    output logic   load_o,
    output logic   step_o
);
    zt_state_e state_q, state_d, resume_q, cur_st;

    // state register; remember where sleep was entered from
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            resume_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
            if (state_q != ST_SLEEP && state_d == ST_SLEEP)
                resume_q <= state_q;
        end
    end

    // next state and command outputs
    always_comb begin
        cur_st  = (state_q == ST_SLEEP) ? resume_q : state_q;
        state_d = cur_st;
        op_o    = OP_NONE;
        load_o  = 1'b0;
        step_o  = 1'b0;
        if (sleep) begin
            state_d = ST_SLEEP;
        end else if (adv) begin
            unique case (cur_st)
                ST_RD_BURST: begin op_o = OP_READ;  step_o = 1'b1; end
                ST_WR_BURST: begin op_o = OP_WRITE; step_o = 1'b1; end
                ST_IDLE, ST_SLEEP: begin end
            endcase
        end else if (sel) begin
            load_o  = 1'b1;
            op_o    = wr_n ? OP_READ : OP_WRITE;
            state_d = wr_n ? ST_RD_BURST : ST_WR_BURST;
        end else begin
            state_d = ST_IDLE;
        end
    end

    // deselect closes any open burst
    assert_desel_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && !adv && !sel) |=> (state_q == ST_IDLE));

    // sleep is held, and the saved state survives it
    assert_sleep_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SLEEP && sleep) |=> (state_q == ST_SLEEP && $stable(resume_q)));
endmodule

// File: rtl/zt_burst_ctr.sv
module zt_burst_ctr #(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lin,
    input  logic          load,
    input  logic          step,
    input  logic [AW-1:0] addr_i,
    output logic [AW-1:0] addr_o
);
    logic [AW-1:0] base_q, last_q;
    logic [1:0]    cnt_q, cnt_nx, lo;

    assign cnt_nx = cnt_q + 2'd1;
    assign lo     = lin ? (base_q[1:0] + cnt_nx) : (base_q[1:0] ^ cnt_nx);
    assign addr_o = load ? addr_i : {base_q[AW-1:2], lo};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= 2'd0;
            last_q <= '0;
        end else if (load) begin
            base_q <= addr_i;
            cnt_q  <= 2'd0;
            last_q <= addr_i;
        end else if (step) begin
            cnt_q  <= cnt_nx;
            last_q <= addr_o;
        end
    end

    // linear steps move by one inside the aligned group of four
    assert_lin_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && lin) |-> (addr_o[1:0] == last_q[1:0] + 2'd1));

    // a burst never leaves its group
    assert_group_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |-> (addr_o[AW-1:2] == last_q[AW-1:2]));
endmodule

// File: rtl/zt_datapath.sv
module zt_datapath
    import zt_pkg::*;
#(
    parameter int DW    = 32,
    parameter int NB    = 4,
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  zt_op_e        op_i,
    input  logic [AW-1:0] addr_i,
    input  logic [NB-1:0] lane_n_i,
    input  logic [DW-1:0] bus_in,
    input  logic          out_en_n,
    output logic [DW-1:0] bus_out,
    output logic          bus_oe,
    output logic          rd_slot_o,
    output logic          wr_slot_o
);
    localparam int LW   = DW / NB;
    localparam int PIPE = 3;

    zt_op_e        op_q   [PIPE];
    logic [AW-1:0] addr_q [PIPE];
    logic [NB-1:0] lane_q [PIPE];
    logic [DW-1:0] rd_word, rdata_q;
    logic          rvalid_q, wr_slot;

    assign wr_slot = (op_q[PIPE-1] == OP_WRITE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < PIPE; i++) begin
                op_q[i]   <= OP_NONE;
                addr_q[i] <= '0;
                lane_q[i] <= '1;
            end
            rvalid_q <= 1'b0;
            rdata_q  <= '0;
        end else begin
            op_q[0]   <= op_i;
            addr_q[0] <= addr_i;
            lane_q[0] <= lane_n_i;
            for (int i = 1; i < PIPE; i++) begin
                op_q[i]   <= op_q[i-1];
                addr_q[i] <= addr_q[i-1];
                lane_q[i] <= lane_q[i-1];
            end
            rvalid_q <= (op_q[1] == OP_READ);
            if (op_q[1] == OP_READ)
                rdata_q <= rd_word;
        end
    end

    // one storage array per byte lane; bypass the write closing this edge
    for (genvar b = 0; b < NB; b++) begin : g_lane
        logic [LW-1:0] mem [DEPTH];
        logic          lane_wr, fwd;

        assign lane_wr = wr_slot && !lane_q[PIPE-1][b];
        assign fwd     = lane_wr && (addr_q[PIPE-1] == addr_q[1]);

        always_ff @(posedge clk) begin
            if (lane_wr)
                mem[addr_q[PIPE-1]] <= bus_in[b*LW +: LW];
        end

        assign rd_word[b*LW +: LW] = fwd ? bus_in[b*LW +: LW] : mem[addr_q[1]];
    end

    assign bus_out   = rdata_q;
    assign bus_oe    = rvalid_q && !out_en_n;
    assign rd_slot_o = rvalid_q;
    assign wr_slot_o = wr_slot;

    // a bus slot belongs to a read or a write, never both
    assert_slot_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(rvalid_q && wr_slot));
endmodule

// File: rtl/zt_sync_sram.sv
module zt_sync_sram
    import zt_pkg::*;
#(
    parameter int  DATA_W = 32,
    parameter int  LANES  = 4,
    parameter int  DEPTH  = 64,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              burst_adv,
    input  logic              wr_n,
    input  logic              cs0_n,
    input  logic              cs1,
    input  logic              cs2_n,
    input  logic [LANES-1:0]  lane_wr_n,
    input  logic              lin_order,
    input  logic              out_en_n,
    input  logic              sleep,
    inout  wire  [DATA_W-1:0] data_io
);
    zt_op_e            ctl_op;
    logic              ctl_load, ctl_step, sel;
    logic [ADDR_W-1:0] cmd_addr;
    logic [DATA_W-1:0] bus_out;
    logic              bus_oe, rd_slot, wr_slot;

    assign sel = !cs0_n && cs1 && !cs2_n;

    zt_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .sleep  (sleep),
        .adv    (burst_adv),
        .sel    (sel),
        .wr_n   (wr_n),
        .op_o   (ctl_op),
        .load_o (ctl_load),
        .step_o (ctl_step)
    );

    zt_burst_ctr #(.AW(ADDR_W)) u_burst (
        .clk    (clk),
        .rst_n  (rst_n),
        .lin    (lin_order),
        .load   (ctl_load),
        .step   (ctl_step),
        .addr_i (addr),
        .addr_o (cmd_addr)
    );

    zt_datapath #(.DW(DATA_W), .NB(LANES), .DEPTH(DEPTH), .AW(ADDR_W)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_i      (ctl_op),
        .addr_i    (cmd_addr),
        .lane_n_i  (lane_wr_n),
        .bus_in    (data_io),
        .out_en_n  (out_en_n),
        .bus_out   (bus_out),
        .bus_oe    (bus_oe),
        .rd_slot_o (rd_slot),
        .wr_slot_o (wr_slot)
    );

    assign data_io = bus_oe ? bus_out : {DATA_W{1'bz}};

    assert_rd_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_op == OP_READ) |=> ##2 rd_slot);

    assert_wr_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_op == OP_WRITE) |=> ##2 wr_slot);

    assert_sleep_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> (ctl_op == OP_NONE && !ctl_load));
endmodule

// File: tb/zt_sync_sram_tb.sv
module zt_sync_sram_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  addr = '0;
    logic        burst_adv = 1'b0, wr_n = 1'b1;
    logic        cs0_n = 1'b1, cs1 = 1'b0, cs2_n = 1'b1;
    logic [3:0]  lane_wr_n = 4'hF;
    logic        lin_order = 1'b1, out_en_n = 1'b0, sleep = 1'b0;
    logic [31:0] tb_dq = '0;
    logic        tb_drv = 1'b0;
    wire  [31:0] data_io;

    int total = 0, bad = 0;
    bit done = 1'b0;

    for (genvar g = 0; g < 32; g++) begin : g_pd
        pulldown (data_io[g]);
    end
    assign data_io = tb_drv ? tb_dq : 32'bz;

    always #10 clk = ~clk;

    zt_sync_sram u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .burst_adv(burst_adv), .wr_n(wr_n),
        .cs0_n(cs0_n), .cs1(cs1), .cs2_n(cs2_n), .lane_wr_n(lane_wr_n),
        .lin_order(lin_order), .out_en_n(out_en_n), .sleep(sleep), .data_io(data_io)
    );

    // reference model state
    logic [31:0] shadow [64];
    int          m_st = 0;
    logic [5:0]  m_base = '0;
    logic [1:0]  m_cnt = '0;
    int          p_op [3];
    logic [5:0]  p_ad [3];
    logic [3:0]  p_bw [3];
    logic [31:0] p_wd [3];
    string       p_tg [3];
    bit          p_oe [3];

    // stimulus vectors: {adv, cs0_n, cs1, cs2_n, wr_n, sleep, addr[6], lanes[4], wdata[32], tag[4]}
    localparam int TAB_N = 13;
    localparam logic [51:0] TAB [TAB_N] = '{
        {1'b0, 3'b010, 1'b0, 1'b0, 6'd8,  4'h0, 32'h1111_1111, 4'd0},
        {1'b0, 3'b010, 1'b0, 1'b0, 6'd9,  4'h0, 32'h2222_2222, 4'd0},
        {1'b0, 3'b010, 1'b1, 1'b0, 6'd8,  4'hF, 32'h0,         4'd3},
        {1'b0, 3'b010, 1'b0, 1'b0, 6'd8,  4'hA, 32'hAABB_CCDD, 4'd0},
        {1'b0, 3'b010, 1'b1, 1'b0, 6'd8,  4'hF, 32'h0,         4'd12},
        {1'b0, 3'b010, 1'b1, 1'b0, 6'd9,  4'hF, 32'h0,         4'd4},
        {1'b0, 3'b010, 1'b0, 1'b0, 6'd10, 4'h0, 32'h3333_3333, 4'd0},
        {1'b0, 3'b010, 1'b1, 1'b0, 6'd10, 4'hF, 32'h0,         4'd12},
        {1'b0, 3'b000, 1'b0, 1'b0, 6'd9,  4'h0, 32'h5555_5555, 4'd6},
        {1'b0, 3'b010, 1'b1, 1'b0, 6'd9,  4'hF, 32'h0,         4'd6},
        {1'b0, 3'b010, 1'b0, 1'b1, 6'd9,  4'h0, 32'h6666_6666, 4'd11},
        {1'b0, 3'b010, 1'b1, 1'b0, 6'd9,  4'hF, 32'h0,         4'd11},
        {1'b0, 3'b010, 1'b1, 1'b0, 6'd8,  4'hF, 32'h0,         4'd5}
    };

    function automatic string tag_name(input logic [3:0] t);
        case (t)
            4'd3:    return "R3";
            4'd4:    return "R4";
            4'd5:    return "R5";
            4'd6:    return "R6";
            4'd11:   return "R11";
            4'd12:   return "R12";
            default: return "";
        endcase
    endfunction

    task automatic chk(input bit ok, input string tg, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tg, act, exp);
        end
    endtask

    // serve the bus slot of the command issued three calls ago
    task automatic service_slot();
        if (p_op[2] == 2) begin
            tb_dq  = p_wd[2];
            tb_drv = 1'b1;
            for (int b = 0; b < 4; b++)
                if (!p_bw[2][b]) shadow[p_ad[2]][b*8 +: 8] = p_wd[2][b*8 +: 8];
        end else begin
            tb_drv = 1'b0;
            #1;
            if (p_op[2] == 1) begin
                if (p_oe[2]) begin
                    out_en_n = 1'b1;
                    #1;
                    chk(data_io == 32'h0, "R10", data_io, 32'h0);
                    out_en_n = 1'b0;
                    #1;
                end
                chk(data_io == shadow[p_ad[2]], p_tg[2], data_io, shadow[p_ad[2]]);
            end else if (p_tg[2] != "") begin
                chk(data_io == 32'h0, p_tg[2], data_io, 32'h0);
            end
        end
    endtask

    task automatic step(input logic a, input logic c0n, input logic c1, input logic c2n,
                        input logic wn, input logic slp, input logic [5:0] ad,
                        input logic [3:0] bw, input logic [31:0] wd, input string tg, input bit oec);
        int         op;
        logic [5:0] ea;
        @(negedge clk);
        service_slot();
        op = 0;
        ea = ad;
        if (slp) begin
            op = 0;
        end else if (a) begin
            if (m_st != 0) begin
                m_cnt = m_cnt + 2'd1;
                ea = {m_base[5:2], lin_order ? (m_base[1:0] + m_cnt) : (m_base[1:0] ^ m_cnt)};
                op = m_st;
            end
        end else if (!c0n && c1 && !c2n) begin
            m_base = ad;
            m_cnt  = 2'd0;
            op     = wn ? 1 : 2;
            m_st   = op;
        end else begin
            m_st = 0;
        end
        for (int i = 2; i > 0; i--) begin
            p_op[i] = p_op[i-1]; p_ad[i] = p_ad[i-1]; p_bw[i] = p_bw[i-1];
            p_wd[i] = p_wd[i-1]; p_tg[i] = p_tg[i-1]; p_oe[i] = p_oe[i-1];
        end
        p_op[0] = op; p_ad[0] = ea; p_bw[0] = bw; p_wd[0] = wd; p_tg[0] = tg; p_oe[0] = oec;
        burst_adv = a; cs0_n = c0n; cs1 = c1; cs2_n = c2n;
        wr_n = wn; sleep = slp; addr = ad; lane_wr_n = bw;
    endtask

    task automatic idle(input string tg);
        step(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 6'd0, 4'hF, 32'h0, tg, 1'b0);
    endtask
    task automatic rd(input logic [5:0] ad, input string tg, input bit oec);
        step(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, ad, 4'hF, 32'h0, tg, oec);
    endtask
    task automatic wr(input logic [5:0] ad, input logic [31:0] wd);
        step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, ad, 4'h0, wd, "", 1'b0);
    endtask
    // advance with selects off and the write enable low, both to be ignored
    task automatic adv(input logic slp, input logic [31:0] wd, input string tg);
        step(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, slp, 6'd63, 4'h0, wd, tg, 1'b0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 3; i++) begin
            p_op[i] = 0; p_ad[i] = '0; p_bw[i] = 4'hF; p_wd[i] = '0; p_tg[i] = ""; p_oe[i] = 1'b0;
        end
        repeat (3) @(negedge clk);
        #1 chk(data_io == 32'h0, "R1", data_io, 32'h0);
        rst_n = 1'b1;
        repeat (2) begin
            @(negedge clk);
            #1 chk(data_io == 32'h0, "R1", data_io, 32'h0);
        end

        // table walk: mixed back-to-back traffic, lanes, selects, sleep
        for (int v = 0; v < TAB_N; v++)
            step(TAB[v][51], TAB[v][50], TAB[v][49], TAB[v][48], TAB[v][47], TAB[v][46],
                 TAB[v][45:40], TAB[v][39:36], TAB[v][35:4], tag_name(TAB[v][3:0]), 1'b0);
        repeat (3) idle("");

        // fill a group of four with distinct words
        for (int k = 0; k < 4; k++) wr(6'd16 + 6'(k), 32'hC0DE_0010 + 32'(k));
        // R7 linear burst from 17: 17,18,19,16
        lin_order = 1'b1;
        rd(6'd17, "R7", 1'b0);
        repeat (3) adv(1'b0, 32'hDEAD_0000, "R7");
        // R8 interleaved burst from 17: 17,16,19,18
        idle("");
        lin_order = 1'b0;
        rd(6'd17, "R8", 1'b0);
        repeat (3) adv(1'b0, 32'hDEAD_0001, "R8");
        // R9 write burst by advance, then read it back
        idle("");
        lin_order = 1'b1;
        wr(6'd22, 32'h9000_0022);
        for (int k = 1; k < 4; k++) adv(1'b0, 32'h9000_0000 + 32'(k), "");
        rd(6'd22, "R9", 1'b0);
        repeat (3) adv(1'b0, 32'h0, "R9");
        // R9 advance with no open burst does nothing
        idle("");
        adv(1'b0, 32'h7777_7777, "R9");
        rd(6'd21, "R9", 1'b0);
        // R11 burst position held across sleep
        idle("");
        rd(6'd17, "R11", 1'b0);
        adv(1'b1, 32'h0, "R11");
        adv(1'b1, 32'h0, "R11");
        adv(1'b0, 32'h0, "R11");
        // R10 output enable, R2 read latency
        idle("");
        rd(6'd16, "R2", 1'b1);
        repeat (3) idle("");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule